// File: doc/BRIEF.md
# Branch and Effective-Address Unit

This unit works out, for a 16-bit word-addressed processor, where an instruction reads or writes memory and where execution continues afterwards. It takes the current program counter, the instruction word, the value of the base register the register file has already read for that instruction, the three condition flags and, when the instruction needs it, a word that has already come back from memory. From these it gives the effective address, the next program counter, a redirect flag, a request to save the incremented program counter into the link register R7, and a request for a second memory access for indirect loads and stores.

A single adder covers every address form. Its left operand is the incremented program counter, the base register or zero. Its right operand is a sign-extended 9-, 6- or 11-bit offset or a zero-extended 8-bit vector. A multi-cycle controller outside the unit sequences the memory accesses and presents the returned word on `mem_word_i`. It also owns the register file and the memory. The unit's outputs pass through an optional register stage (`REG_OUT`, default 1).

Top module: `pc_ea_unit`

## Requirements
- R1: For opcodes 0010, 0011, 1010, 1011, 1110 and 0000 (instruction bits [15:12]), `ea_o` equals pc_i+1 plus bits [8:0] sign-extended, modulo 2^16 (pc x4018 with offset x1AF gives x3FC8). Opcodes 0010, 0011, 1010, 1011 and 0110/0111 raise `mem_req_o`.
- R2: For opcodes 0110 and 0111, `ea_o` equals `base_i` plus bits [5:0] sign-extended, modulo 2^16.
- R3: For opcodes 1010 and 1011, `ind_req_o` is 1 and `final_addr_o` equals `mem_word_i`. For every other opcode, `ind_req_o` is 0 and `final_addr_o` equals `ea_o`.
- R4: For opcode 0000, the branch is taken when (bits [11:9] AND `flags_i`) is non-zero. Bit 11 and `flags_i[2]` are negative, bit 10 and `flags_i[1]` are zero, bit 9 and `flags_i[0]` are positive. When taken, `taken_o`=1 and `next_pc_o`=`ea_o`. Otherwise `taken_o`=0 and `next_pc_o`=pc_i+1, so a mask of 000 never branches.
- R5: For opcode 1100, `next_pc_o`=`base_i` and `taken_o`=1. `link_we_o` is 0 and `mem_req_o` is 0.
- R6: For opcode 0100 with bit 11=1, `ea_o` and `next_pc_o` equal pc_i+1 plus bits [10:0] sign-extended. With bit 11=0, `next_pc_o`=`base_i`. Both forms set `taken_o`=1 and `link_we_o`=1, and `link_data_o`=pc_i+1 at all times.
- R7: For opcode 1111, `ea_o` is bits [7:0] zero-extended, `mem_req_o`=1, `next_pc_o`=`mem_word_i`, `taken_o`=1 and `link_we_o`=1.
- R8: For opcode 1110, `addr_wb_o`=1 (write `ea_o` to the destination register) and `mem_req_o`=0. No other opcode raises `addr_wb_o`.
- R9: For opcodes 0001, 0101, 1001, 1000 and 1101, `next_pc_o`=pc_i+1. `taken_o`, `link_we_o`, `mem_req_o`, `ind_req_o` and `addr_wb_o` are all 0.
- R10: With REG_OUT=1, outputs appear one clock after their inputs. `out_valid_o` follows `in_valid` with one clock of delay and is 0 after a synchronous active-low reset. While `out_valid_o` is 0, all five strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs carry an instruction this cycle |
| pc_i | input | WORD_W | Address of the current instruction |
| instr_i | input | 16 | Instruction word |
| base_i | input | WORD_W | Value of the base register named by bits [8:6] |
| flags_i | input | 3 | Condition flags {negative, zero, positive} |
| mem_word_i | input | WORD_W | Word returned by the first memory access (pointer or trap target) |
| out_valid_o | output | 1 | Outputs are valid |
| ea_o | output | WORD_W | Adder result: effective address or relative target |
| final_addr_o | output | WORD_W | Operand address after any indirection |
| next_pc_o | output | WORD_W | Next program counter |
| taken_o | output | 1 | Control leaves the sequential path |
| link_we_o | output | 1 | Write `link_data_o` into R7 |
| link_data_o | output | WORD_W | Incremented program counter |
| mem_req_o | output | 1 | Instruction accesses memory at `ea_o` |
| ind_req_o | output | 1 | Second access at `final_addr_o` needed |
| addr_wb_o | output | 1 | Write `ea_o` to the destination register |

## Verification
The hardest case to reach is where the adder's operand selection meets wrap-around. That happens with a program counter at xFFFE or xFFFF, or a base near the top of the address space, combined with a negative or maximal offset, and while a branch mask only partly matches the flags. Directed cases place the program counter at the wrap boundary and walk every mask against every single-flag setting. A long random run then mixes opcodes, extreme offsets, pointers and flags against a behavioural model that holds expectations in a queue and compares them one clock later.

// File: rtl/pc_ea_pkg.sv
// Package: opcode values and operand-select encodings shared by the
// branch / effective-address unit. Assumes a 4-bit opcode in bits [15:12].
package pc_ea_pkg;

    localparam int INSTR_W = 16;

    typedef enum logic [3:0] {
        OP_BR   = 4'b0000,
        OP_LD   = 4'b0010,
        OP_ST   = 4'b0011,
        OP_JSR  = 4'b0100,
        OP_LDR  = 4'b0110,
        OP_STR  = 4'b0111,
        OP_LDI  = 4'b1010,
        OP_STI  = 4'b1011,
        OP_JMP  = 4'b1100,
        OP_LEA  = 4'b1110,
        OP_TRAP = 4'b1111
    } opcode_e;

    // Left adder operand
    typedef enum logic [1:0] {
        A_PCINC = 2'd0,
        A_BASE  = 2'd1,
        A_ZERO  = 2'd2
    } a_sel_e;

    // Right adder operand
    typedef enum logic [1:0] {
        B_OFF9  = 2'd0,
        B_OFF6  = 2'd1,
        B_OFF11 = 2'd2,
        B_VEC8  = 2'd3
    } b_sel_e;

    // Decoded control for one instruction
    typedef struct packed {
        a_sel_e a_sel;
        b_sel_e b_sel;
        logic   is_br;
        logic   is_jmp;
        logic   is_jsr_rel;
        logic   is_jsr_reg;
        logic   is_trap;
        logic   is_ind;
        logic   mem_req;
        logic   addr_wb;
    } ctl_t;

endpackage

// File: rtl/pc_ea_decode.sv
// Decoder: turns the instruction opcode into operand selects and
// instruction-class flags. Purely combinational; no knowledge of data.
module pc_ea_decode
    import pc_ea_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output ctl_t               ctl_o
);

    // Classify the opcode and choose adder operands
    always_comb begin
        ctl_o       = '0;
        ctl_o.a_sel = A_PCINC;
        ctl_o.b_sel = B_OFF9;
        case (instr_i[15:12])
            OP_BR:          ctl_o.is_br = 1'b1;
            OP_LD, OP_ST:   ctl_o.mem_req = 1'b1;
            OP_LDI, OP_STI: begin
                ctl_o.mem_req = 1'b1;
                ctl_o.is_ind  = 1'b1;
            end
            OP_LEA:         ctl_o.addr_wb = 1'b1;
            OP_LDR, OP_STR: begin
                ctl_o.a_sel   = A_BASE;
                ctl_o.b_sel   = B_OFF6;
                ctl_o.mem_req = 1'b1;
            end
            OP_JMP:         ctl_o.is_jmp = 1'b1;
            OP_JSR: begin
                ctl_o.b_sel      = B_OFF11;
                ctl_o.is_jsr_rel = instr_i[11];
                ctl_o.is_jsr_reg = ~instr_i[11];
            end
            OP_TRAP: begin
                ctl_o.a_sel   = A_ZERO;
                ctl_o.b_sel   = B_VEC8;
                ctl_o.is_trap = 1'b1;
                ctl_o.mem_req = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pc_ea_adder.sv
// Shared address adder: one left operand (PC+1, base, or zero) plus one
// extended offset field of the instruction. Sums wrap modulo 2^WORD_W.
// Assumes WORD_W >= 11 so every offset field fits.
module pc_ea_adder
    import pc_ea_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0]  pc_inc_i,
    input  logic [WORD_W-1:0]  base_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  a_sel_e             a_sel_i,
    input  b_sel_e             b_sel_i,
    output logic [WORD_W-1:0]  sum_o
);

    logic [WORD_W-1:0] opa;
    logic [WORD_W-1:0] opb;

    // Left operand select
    always_comb begin
        case (a_sel_i)
            A_BASE:  opa = base_i;
            A_ZERO:  opa = '0;
            default: opa = pc_inc_i;
        endcase
    end

    // Right operand: extend the selected field to full width
    always_comb begin
        case (b_sel_i)
            B_OFF6:  opb = {{(WORD_W-6){instr_i[5]}},   instr_i[5:0]};
            B_OFF11: opb = {{(WORD_W-11){instr_i[10]}}, instr_i[10:0]};
            B_VEC8:  opb = {{(WORD_W-8){1'b0}},         instr_i[7:0]};
            default: opb = {{(WORD_W-9){instr_i[8]}},   instr_i[8:0]};
        endcase
    end

    assign sum_o = opa + opb;

endmodule

// File: rtl/pc_ea_cond.sv
// Branch condition: true when any requested flag is currently set.
// Mask and flag bits share the order {negative, zero, positive}.
module pc_ea_cond (
    input  logic [2:0] mask_i,
    input  logic [2:0] flags_i,
    output logic       hit_o
);

    // Reduce the masked flags to a single condition
    always_comb hit_o = |(mask_i & flags_i);

endmodule

// File: rtl/pc_ea_unit.sv
// Branch and effective-address unit. Computes addresses, next PC, link
// and access requests for one instruction per cycle. Assumes the caller
// already read base_i from the register file and, for indirect or trap
// instructions, presents the first access's result on mem_word_i.
// REG_OUT=1 adds one register stage (synchronous active-low reset).
module pc_ea_unit
    import pc_ea_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  pc_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [WORD_W-1:0]  base_i,
    input  logic [2:0]         flags_i,
    input  logic [WORD_W-1:0]  mem_word_i,
    output logic               out_valid_o,
    output logic [WORD_W-1:0]  ea_o,
    output logic [WORD_W-1:0]  final_addr_o,
    output logic [WORD_W-1:0]  next_pc_o,
    output logic               taken_o,
    output logic               link_we_o,
    output logic [WORD_W-1:0]  link_data_o,
    output logic               mem_req_o,
    output logic               ind_req_o,
    output logic               addr_wb_o
);

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] ea;
        logic [WORD_W-1:0] fin;
        logic [WORD_W-1:0] npc;
        logic              taken;
        logic              link_we;
        logic [WORD_W-1:0] link;
        logic              mem_req;
        logic              ind_req;
        logic              addr_wb;
    } res_t;

    ctl_t              ctl;
    logic [WORD_W-1:0] pc_inc;
    logic [WORD_W-1:0] sum;
    logic              cond_hit;
    res_t              res_c;
    res_t              res_q;

    assign pc_inc = pc_i + 1'b1;

    pc_ea_decode u_dec (
        .instr_i (instr_i),
        .ctl_o   (ctl)
    );

    pc_ea_adder #(.WORD_W(WORD_W)) u_add (
        .pc_inc_i (pc_inc),
        .base_i   (base_i),
        .instr_i  (instr_i),
        .a_sel_i  (ctl.a_sel),
        .b_sel_i  (ctl.b_sel),
        .sum_o    (sum)
    );

    pc_ea_cond u_cond (
        .mask_i  (instr_i[11:9]),
        .flags_i (flags_i),
        .hit_o   (cond_hit)
    );

    // Assemble the combinational result; strobes gated by in_valid
    always_comb begin
        res_c         = '0;
        res_c.valid   = in_valid;
        res_c.ea      = sum;
        res_c.fin     = ctl.is_ind ? mem_word_i : sum;
        res_c.link    = pc_inc;
        if ((ctl.is_br && cond_hit) || ctl.is_jsr_rel)
            res_c.npc = sum;
        else if (ctl.is_jmp || ctl.is_jsr_reg)
            res_c.npc = base_i;
        else if (ctl.is_trap)
            res_c.npc = mem_word_i;
        else
            res_c.npc = pc_inc;
        res_c.taken   = in_valid & ((ctl.is_br & cond_hit) | ctl.is_jmp |
                                    ctl.is_jsr_rel | ctl.is_jsr_reg | ctl.is_trap);
        res_c.link_we = in_valid & (ctl.is_jsr_rel | ctl.is_jsr_reg | ctl.is_trap);
        res_c.mem_req = in_valid & ctl.mem_req;
        res_c.ind_req = in_valid & ctl.is_ind;
        res_c.addr_wb = in_valid & ctl.addr_wb;
    end

    generate
        if (REG_OUT) begin : g_reg
            // Output stage register with synchronous clear of strobes
            always_ff @(posedge clk) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_c;
            end
        end else begin : g_comb
            assign res_q = res_c;
        end
    endgenerate

    assign out_valid_o  = res_q.valid;
    assign ea_o         = res_q.ea;
    assign final_addr_o = res_q.fin;
    assign next_pc_o    = res_q.npc;
    assign taken_o      = res_q.taken;
    assign link_we_o    = res_q.link_we;
    assign link_data_o  = res_q.link;
    assign mem_req_o    = res_q.mem_req;
    assign ind_req_o    = res_q.ind_req;
    assign addr_wb_o    = res_q.addr_wb;

endmodule

// File: rtl/pc_ea_unit_chk.sv
// Checker for pc_ea_unit: port-level properties over the output stage.
// Assumes a clean synchronous active-low reset.
module pc_ea_unit_chk #(
    parameter int WORD_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] pc_i,
    input logic              out_valid_o,
    input logic [WORD_W-1:0] ea_o,
    input logic [WORD_W-1:0] final_addr_o,
    input logic [WORD_W-1:0] next_pc_o,
    input logic              taken_o,
    input logic              link_we_o,
    input logic [WORD_W-1:0] link_data_o,
    input logic              mem_req_o,
    input logic              ind_req_o,
    input logic              addr_wb_o
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> !(taken_o | link_we_o | mem_req_o | ind_req_o | addr_wb_o)); // R10

    AST_LEA_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wb_o |-> !mem_req_o); // R8

    AST_IND_IS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        ind_req_o |-> (mem_req_o && !link_we_o && !taken_o)); // R3

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_wb_o, ind_req_o, link_we_o})); // R6

    AST_SEQ_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !taken_o) |-> (next_pc_o == link_data_o)); // R9

    AST_NOIND_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !ind_req_o) |-> (final_addr_o == ea_o)); // R3

    generate
        if (REG_OUT) begin : g_lat
            AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_valid_o == $past(in_valid))); // R10

            AST_LINK_PC: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && link_we_o) |-> (link_data_o == $past(pc_i) + 1'b1)); // R6
        end
    endgenerate

endmodule

bind pc_ea_unit pc_ea_unit_chk #(.WORD_W(WORD_W), .REG_OUT(REG_OUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .pc_i         (pc_i),
    .out_valid_o  (out_valid_o),
    .ea_o         (ea_o),
    .final_addr_o (final_addr_o),
    .next_pc_o    (next_pc_o),
    .taken_o      (taken_o),
    .link_we_o    (link_we_o),
    .link_data_o  (link_data_o),
    .mem_req_o    (mem_req_o),
    .ind_req_o    (ind_req_o),
    .addr_wb_o    (addr_wb_o)
);

// File: tb/pc_ea_unit_tb.sv
// Bench: behavioural reference model, expectations queued and compared
// one clock after each input (REG_OUT=1).
module pc_ea_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] pc_i = '0, instr_i = '0, base_i = '0, mem_word_i = '0;
    logic [2:0]  flags_i = '0;
    logic        out_valid_o, taken_o, link_we_o, mem_req_o, ind_req_o, addr_wb_o;
    logic [15:0] ea_o, final_addr_o, next_pc_o, link_data_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pc_ea_unit #(.WORD_W(16), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_i(pc_i),
        .instr_i(instr_i), .base_i(base_i), .flags_i(flags_i),
        .mem_word_i(mem_word_i), .out_valid_o(out_valid_o), .ea_o(ea_o),
        .final_addr_o(final_addr_o), .next_pc_o(next_pc_o), .taken_o(taken_o),
        .link_we_o(link_we_o), .link_data_o(link_data_o), .mem_req_o(mem_req_o),
        .ind_req_o(ind_req_o), .addr_wb_o(addr_wb_o)
    );

    typedef struct packed {
        logic        v;
        logic        ea_care;
        logic [15:0] ea;
        logic [15:0] fin;
        logic [15:0] npc;
        logic        taken, link, mreq, ind, awb;
        logic [15:0] ldata;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int sx(input int val, input int bits);
        return (val >= (1 << (bits - 1))) ? val - (1 << bits) : val;
    endfunction

    // Reference model built from the requirements
    task automatic model(input logic v, input logic [15:0] pc, ir, base,
                         input logic [2:0] fl, input logic [15:0] mw);
        exp_t  e;
        string tag;
        int    op;
        int    inc;
        op      = int'(ir[15:12]);
        inc     = int'(pc) + 1;
        e       = '0;
        e.v     = v;
        e.ldata = 16'(inc);
        e.npc   = 16'(inc);
        tag     = "R9";
        case (op)
            0, 2, 3, 10, 11, 14: begin
                e.ea_care = 1'b1;
                e.ea = 16'(inc + sx(int'(ir[8:0]), 9));
                tag  = (op == 0) ? "R4" : (op >= 10 && op <= 11) ? "R3" :
                       (op == 14) ? "R8" : "R1";
                if (op == 2 || op == 3 || op == 10 || op == 11) e.mreq = 1'b1;
                if (op == 10 || op == 11) e.ind = 1'b1;
                if (op == 14) e.awb = 1'b1;
                if (op == 0 && ((ir[11] && fl[2]) || (ir[10] && fl[1]) || (ir[9] && fl[0]))) begin
                    e.taken = 1'b1;
                    e.npc   = e.ea;
                end
            end
            6, 7: begin
                tag = "R2";
                e.ea_care = 1'b1;
                e.ea   = 16'(int'(base) + sx(int'(ir[5:0]), 6));
                e.mreq = 1'b1;
            end
            12: begin
                tag = "R5";
                e.npc = base;
                e.taken = 1'b1;
            end
            4: begin
                tag = "R6";
                e.taken = 1'b1;
                e.link  = 1'b1;
                if (ir[11]) begin
                    e.ea_care = 1'b1;
                    e.ea  = 16'(inc + sx(int'(ir[10:0]), 11));
                    e.npc = e.ea;
                end else begin
                    e.npc = base;
                end
            end
            15: begin
                tag = "R7";
                e.ea_care = 1'b1;
                e.ea   = {8'h00, ir[7:0]};
                e.npc  = mw;
                e.mreq = 1'b1;
                e.taken = 1'b1;
                e.link = 1'b1;
            end
            default: ;
        endcase
        e.fin = e.ind ? mw : e.ea;
        if (!v) begin
            e.taken = 0; e.link = 0; e.mreq = 0; e.ind = 0; e.awb = 0;
            tag = "R10";
        end
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    // Compare outputs with the oldest queued expectation
    task automatic compare();
        exp_t  e;
        string t;
        if (expq.size() == 0) return;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk("R10", "out_valid", int'(out_valid_o), int'(e.v));
        chk(t, "taken", int'(taken_o), int'(e.taken));
        chk(t, "link_we", int'(link_we_o), int'(e.link));
        chk(t, "mem_req", int'(mem_req_o), int'(e.mreq));
        chk(t, "ind_req", int'(ind_req_o), int'(e.ind));
        chk(t, "addr_wb", int'(addr_wb_o), int'(e.awb));
        if (e.v) begin
            chk(t, "next_pc", int'(next_pc_o), int'(e.npc));
            chk(t, "link_data", int'(link_data_o), int'(e.ldata));
            if (e.ea_care) begin
                chk(t, "ea", int'(ea_o), int'(e.ea));
                chk(t, "final_addr", int'(final_addr_o), int'(e.fin));
            end
        end
    endtask

    // One cycle: check previous result, then drive new inputs at negedge
    task automatic send(input logic v, input logic [15:0] pc, ir, base,
                        input logic [2:0] fl, input logic [15:0] mw);
        @(negedge clk);
        compare();
        in_valid = v; pc_i = pc; instr_i = ir; base_i = base;
        flags_i = fl; mem_word_i = mw;
        model(v, pc, ir, base, fl, mw);
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Reset with valid input presented: output must stay invalid (R10)
        in_valid = 1'b1;
        instr_i  = 16'hF025;
        repeat (3) @(negedge clk);
        chk("R10", "reset out_valid", int'(out_valid_o), 0);
        chk("R10", "reset link_we", int'(link_we_o), 0);
        chk("R10", "reset mem_req", int'(mem_req_o), 0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 worked value and other PC-relative forms
        send(1, 16'h4018, 16'h2BAF, 16'h0, 3'b000, 16'h0);
        send(1, 16'h4018, 16'h3A05, 16'h0, 3'b000, 16'h0);
        send(1, 16'hFFFE, 16'h2005, 16'h0, 3'b000, 16'h0);   // wraps to x0004
        // R8 address load
        send(1, 16'h4018, 16'hEBAF, 16'h0, 3'b001, 16'h0);
        // R3 indirect
        send(1, 16'h4018, 16'hABAF, 16'h0, 3'b000, 16'h3D99);
        send(1, 16'h1000, 16'hB0FF, 16'h0, 3'b000, 16'hFFFF);
        // R2 base plus offset
        send(1, 16'h4018, 16'h6BDD, 16'h2345, 3'b000, 16'h0);
        send(1, 16'h4018, 16'h7BE0, 16'h0010, 3'b000, 16'h0);   // -32
        send(1, 16'h0, 16'h6BDF, 16'hFFFF, 3'b000, 16'h0);      // wrap
        // R4 every mask against every single flag
        for (int m = 0; m < 8; m++)
            for (int f = 0; f < 3; f++)
                send(1, 16'h4C18, {4'b0000, 3'(m), 9'h1FD}, 16'h0, 3'(1 << f), 16'h0);
        send(1, 16'hFFFF, 16'h0E00, 16'h0, 3'b010, 16'h0);      // taken to x0000
        // R5 jump and return
        send(1, 16'h4018, 16'hC080, 16'h1234, 3'b000, 16'h0);
        send(1, 16'h4018, 16'hC1C0, 16'h3050, 3'b000, 16'h0);
        // R6 relative and register subroutine calls
        send(1, 16'h4018, 16'h4FFF, 16'h0, 3'b000, 16'h0);
        send(1, 16'h4018, 16'h4C00, 16'h0, 3'b000, 16'h0);
        send(1, 16'h4018, 16'h4080, 16'h8000, 3'b000, 16'h0);
        // R7 trap
        send(1, 16'h3005, 16'hF025, 16'h0, 3'b000, 16'h0520);
        send(1, 16'h3005, 16'hF0FF, 16'h0, 3'b000, 16'hABCD);
        // R9 non-address opcodes
        send(1, 16'h3000, 16'h1262, 16'h5555, 3'b111, 16'h0);
        send(1, 16'h3000, 16'h5FFF, 16'h5555, 3'b111, 16'h0);
        send(1, 16'h3000, 16'h987F, 16'h5555, 3'b111, 16'h0);
        send(1, 16'h3000, 16'h8000, 16'h5555, 3'b111, 16'h0);
        send(1, 16'hFFFF, 16'hD000, 16'h5555, 3'b111, 16'h0);
        // R10 idle cycles with a trap word on the inputs
        send(0, 16'h3000, 16'hF025, 16'h0, 3'b111, 16'h0);
        send(0, 16'h3000, 16'hABAF, 16'h0, 3'b111, 16'h0);
        // Random mix
        for (int i = 0; i < 3000; i++)
            send(($urandom % 8) != 0, 16'($urandom), 16'($urandom), 16'($urandom),
                 3'($urandom), 16'($urandom));
        send(0, 16'h0, 16'h0, 16'h0, 3'b000, 16'h0);
        @(negedge clk);
        compare();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule